// File: doc/BRIEF.md
# Windowed Watchdog Timer

A supervision timer that counts a down-counter from all-ones towards zero at a rate set by a prescaler on the peripheral clock. Software must prove it is alive by writing a two-byte unlock pair to a refresh offset. The timer only accepts that pair while the count sits inside a programmable window. A refresh that arrives too early or too late is a fault. Letting the counter run out is also a fault. Either fault produces a single-cycle request to the reset controller or to the non-maskable interrupt controller, whichever a configuration bit selects.

Configuration comes in as static inputs that an option-word loader would drive: the start mode, the response, the prescaler ratio and the window bounds. A stop input freezes counting while the chip is in a low-power state. The live count and two sticky fault flags are always visible on a status output. Software clears the flags by writing to a second bus offset.

Top module: `wdog_window_top`

## Requirements
- R1: `cfg_div_sel_i` selects the prescaler ratio. Codes 0..5 select 4, 64, 128, 512, 2048 and 8192 clocks per count; codes 6 and 7 also select 8192. The first decrement after a start, reload or fault comes exactly one ratio of running clocks later.
- R2: A write of 00h to offset 0 followed by a write of FFh to offset 0 reloads the counter to all-ones and restarts the prescaler phase. Repeated 00h writes keep the sequence pending. An FFh write with no 00h before it, or a 00h followed by any other value, does not reload.
- R3: With `cfg_auto_start_i`=1 the counter runs from reset release. If the counter is at 0 when a prescaler tick arrives, that is an underflow. This happens ratio x 2^CNT_W clocks after the last reload.
- R4: With `cfg_auto_start_i`=0 the counter holds at all-ones until the first complete refresh pair, which starts counting without a window check. After any fault the counter returns to all-ones and holds there again.
- R5: Let Q = 2^CNT_W / 4. Window start code s (0,1,2,3) sets the upper bound to (4-s)xQ-1. Window end code e (0,1,2,3) sets the lower bound to exQ. While counting, a refresh pair completed with the count outside [lower, upper] is a refresh error, and the counter reloads.
- R6: `cfg_nmi_sel_i`=0 routes faults to `rst_req_o`; `cfg_nmi_sel_i`=1 routes them to `nmi_req_o`. The request rises in the cycle after the fault edge. In auto-start mode the counter reloads to all-ones and keeps counting.
- R7: While `stop_i` is high, both the counter and the prescaler phase hold.
- R8: `status_o` carries the count in bits [CNT_W-1:0], the underflow flag in bit 14 and the refresh-error flag in bit 15. Both flags are sticky. A write to offset 1 clears the underflow flag when data bit 6 is 0 and clears the refresh-error flag when data bit 7 is 0. A fault in the same cycle as a clear leaves the flag set.
- R9: Each request is high for exactly one clock, and the two requests are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_i | input | 1 | Low-power freeze of counter and prescaler |
| cfg_auto_start_i | input | 1 | 1: run from reset, 0: run from first refresh |
| cfg_nmi_sel_i | input | 1 | 1: faults raise NMI request, 0: reset request |
| cfg_div_sel_i | input | 3 | Prescaler ratio code |
| cfg_win_start_i | input | 2 | Window upper-bound code |
| cfg_win_end_i | input | 2 | Window lower-bound code |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_addr_i | input | 1 | 0: refresh, 1: status flag clear |
| bus_wdata_i | input | 8 | Bus write data |
| status_o | output | 16 | Flags and live count |
| rst_req_o | output | 1 | One-clock reset request |
| nmi_req_o | output | 1 | One-clock non-maskable interrupt request |

## Verification
A prescaler phase that is not reset, or that slips by one state, moves every decrement. Because the count is always on `status_o`, the error shows as a wrong count one ratio after a reload. A stuck pending bit in the refresh sequencer shows as a reload, or a missing one, on the next FFh write. A wrong window bound shows as a request on the first refresh near that bound. A lost or doubled fault event shows at the request pins in the cycle after the underflow edge, so checks are made at exact clock counts taken from reset release.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int PRE_W = 13;
  localparam logic       ADDR_REFRESH = 1'b0;
  localparam logic       ADDR_STATUS  = 1'b1;
  localparam logic [7:0] KEY_ARM      = 8'h00;
  localparam logic [7:0] KEY_FIRE     = 8'hFF;
  localparam int ST_UF_BIT  = 14;
  localparam int ST_ERR_BIT = 15;
  localparam int CLR_UF_BIT  = 6;
  localparam int CLR_ERR_BIT = 7;

  // log2 of the clocks per count for each ratio code
  function automatic int unsigned div_exp(input logic [2:0] sel);
    case (sel)
      3'd0:    div_exp = 2;
      3'd1:    div_exp = 6;
      3'd2:    div_exp = 7;
      3'd3:    div_exp = 9;
      3'd4:    div_exp = 11;
      default: div_exp = 13;
    endcase
  endfunction
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       clr_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] limit;

  always_comb begin
    limit  = PRE_W'((32'd1 << div_exp(sel_i)) - 32'd1);
    tick_o = en_i && (cnt_q >= limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + 1'b1;
  end

  // R1: after a phase restart, a full ratio must elapse before the next tick
  assert_no_tick_after_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !tick_o);
  // R7: with the enable low the phase holds
  assert_phase_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_refresh_seq.sv
module wdog_refresh_seq
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic       addr_i,
  input  logic [7:0] data_i,
  output logic       refresh_o
);
  logic armed_q;
  logic hit;

  always_comb begin
    hit       = wr_i && (addr_i == ADDR_REFRESH);
    refresh_o = hit && armed_q && (data_i == KEY_FIRE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   armed_q <= 1'b0;
    else if (hit) armed_q <= (data_i == KEY_ARM);
  end

  // R2: a completed pair consumes the pending state
  assert_pair_consumed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_o |=> !armed_q);
  // R2: an arming write leaves the sequence pending
  assert_arm_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && data_i == KEY_ARM) |=> armed_q);
endmodule

// File: rtl/wdog_window.sv
module wdog_window #(
  parameter int CNT_W = 14
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [1:0]       start_code_i,
  input  logic [1:0]       end_code_i,
  output logic             inside_o
);
  localparam int Q = 1 << (CNT_W - 2);
  localparam logic [CNT_W-1:0] HI_100 = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] HI_75  = CNT_W'(3 * Q - 1);
  localparam logic [CNT_W-1:0] HI_50  = CNT_W'(2 * Q - 1);
  localparam logic [CNT_W-1:0] HI_25  = CNT_W'(Q - 1);
  localparam logic [CNT_W-1:0] LO_0   = '0;
  localparam logic [CNT_W-1:0] LO_25  = CNT_W'(Q);
  localparam logic [CNT_W-1:0] LO_50  = CNT_W'(2 * Q);
  localparam logic [CNT_W-1:0] LO_75  = CNT_W'(3 * Q);

  logic [CNT_W-1:0] hi, lo;

  always_comb begin
    case (start_code_i)
      2'd0:    hi = HI_100;
      2'd1:    hi = HI_75;
      2'd2:    hi = HI_50;
      default: hi = HI_25;
    endcase
    case (end_code_i)
      2'd0:    lo = LO_0;
      2'd1:    lo = LO_25;
      2'd2:    lo = LO_50;
      default: lo = LO_75;
    endcase
    inside_o = (cnt_i <= hi) && (cnt_i >= lo);
  end
endmodule

// File: rtl/wdog_window_top.sv
module wdog_window_top
  import wdog_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stop_i,
  input  logic        cfg_auto_start_i,
  input  logic        cfg_nmi_sel_i,
  input  logic [2:0]  cfg_div_sel_i,
  input  logic [1:0]  cfg_win_start_i,
  input  logic [1:0]  cfg_win_end_i,
  input  logic        bus_wr_i,
  input  logic        bus_addr_i,
  input  logic [7:0]  bus_wdata_i,
  output logic [15:0] status_o,
  output logic        rst_req_o,
  output logic        nmi_req_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic run_q, uf_q, err_q, rst_q, nmi_q;
  logic started, active, tick, in_win;
  logic ref_evt, ref_err, ref_ok, uf_evt, fault_evt;
  logic clr_uf, clr_err;

  wdog_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .en_i(active), .clr_i(ref_ok | fault_evt),
    .sel_i(cfg_div_sel_i), .tick_o(tick)
  );

  wdog_refresh_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .data_i(bus_wdata_i), .refresh_o(ref_evt)
  );

  wdog_window #(.CNT_W(CNT_W)) u_win (
    .cnt_i(cnt_q), .start_code_i(cfg_win_start_i), .end_code_i(cfg_win_end_i),
    .inside_o(in_win)
  );

  always_comb begin
    started   = cfg_auto_start_i | run_q;
    active    = started & ~stop_i;
    uf_evt    = active & tick & (cnt_q == '0);
    ref_err   = ref_evt & started & ~in_win;
    ref_ok    = ref_evt & ~ref_err;
    fault_evt = uf_evt | ref_err;
    clr_uf    = bus_wr_i && (bus_addr_i == ADDR_STATUS) && !bus_wdata_i[CLR_UF_BIT];
    clr_err   = bus_wr_i && (bus_addr_i == ADDR_STATUS) && !bus_wdata_i[CLR_ERR_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_MAX;
      run_q <= 1'b0;
    end else begin
      if (fault_evt || ref_ok) cnt_q <= CNT_MAX;
      else if (active && tick) cnt_q <= cnt_q - 1'b1;
      if (fault_evt)    run_q <= 1'b0;
      else if (ref_ok)  run_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uf_q  <= 1'b0;
      err_q <= 1'b0;
      rst_q <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      uf_q  <= uf_evt  | (uf_q  & ~clr_uf);
      err_q <= ref_err | (err_q & ~clr_err);
      rst_q <= fault_evt & ~cfg_nmi_sel_i;
      nmi_q <= fault_evt &  cfg_nmi_sel_i;
    end
  end

  always_comb begin
    status_o             = '0;
    status_o[CNT_W-1:0]  = cnt_q;
    status_o[ST_UF_BIT]  = uf_q;
    status_o[ST_ERR_BIT] = err_q;
  end

  assign rst_req_o = rst_q;
  assign nmi_req_o = nmi_q;

  // R2: an accepted refresh leaves the counter at all-ones
  assert_refresh_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ok |=> (status_o[CNT_W-1:0] == CNT_MAX));
  // R4: before the first refresh in register-start mode the count holds
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_auto_start_i && !run_q && !ref_evt) |=> $stable(cnt_q));
  // R7: stop freezes the counter
  assert_stop_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !ref_evt) |=> $stable(cnt_q));
  // R8: the underflow flag only rises after an underflow
  assert_uf_flag_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[ST_UF_BIT]) |-> $past(uf_evt));
  // R9: requests are single-cycle and exclusive
  assert_rst_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);
  assert_nmi_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req_o |=> !nmi_req_o);
  assert_req_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req_o && nmi_req_o));
endmodule

// File: tb/tb_wdog_window_top.sv
module tb_wdog_window_top;
  localparam int W   = 6;
  localparam int MAX = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n, stop, auto_st, nmi_sel, wr, addr;
  logic [2:0] div_sel;
  logic [1:0] ws, we;
  logic [7:0] wdata;
  logic [15:0] status;
  logic rst_req, nmi_req;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  wdog_window_top #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .stop_i(stop), .cfg_auto_start_i(auto_st),
    .cfg_nmi_sel_i(nmi_sel), .cfg_div_sel_i(div_sel), .cfg_win_start_i(ws),
    .cfg_win_end_i(we), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .status_o(status), .rst_req_o(rst_req), .nmi_req_o(nmi_req)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int ratio_of(input int sel);
    case (sel)
      0: return 4;
      1: return 64;
      2: return 128;
      3: return 512;
      4: return 2048;
      default: return 8192;
    endcase
  endfunction

  // all tasks start and end just after a falling edge
  task automatic do_reset(input logic a, input logic n, input logic [2:0] d,
                          input logic [1:0] s, input logic [1:0] e);
    rst_n = 1'b0; auto_st = a; nmi_sel = n; div_sel = d; ws = s; we = e;
    stop = 1'b0; wr = 1'b0; addr = 1'b0; wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state;
    do_reset(1'b1, 1'b0, 3'd0, 2'd0, 2'd0);
    check("R8", "status after reset", status, 16'(MAX));
    check("R9", "requests after reset", {14'd0, rst_req, nmi_req}, 16'd0);
  endtask

  task automatic t_underflow_reset;
    int early = 0;
    do_reset(1'b1, 1'b0, 3'd0, 2'd0, 2'd0);
    for (int i = 1; i <= 4 * (MAX + 1); i++) begin
      @(negedge clk);
      if (i < 4 * (MAX + 1) && (rst_req || nmi_req)) early++;
      if (i == 4 * MAX) check("R3", "count reaches zero", status, 16'h0000);
      if (i == 4 * (MAX + 1) - 1) begin
        wr = 1'b1; addr = 1'b1; wdata = 8'h00;
      end
    end
    wr = 1'b0;
    check("R3", "no early request", 16'(early), 16'd0);
    check("R6", "reset request on underflow", {14'd0, rst_req, nmi_req}, 16'b10);
    check("R8", "set wins over clear, count reloaded", status, 16'h4000 | 16'(MAX));
    wait_cyc(1);
    check("R9", "reset request one cycle", {15'd0, rst_req}, 16'd0);
    bus_write(1'b1, 8'hC0);
    check("R8", "writing ones keeps flag", {15'd0, status[14]}, 16'd1);
    bus_write(1'b1, 8'h80);
    check("R8", "writing zero clears flag", {15'd0, status[14]}, 16'd0);
  endtask

  task automatic t_refresh_seq;
    do_reset(1'b1, 1'b1, 3'd0, 2'd0, 2'd0);
    wait_cyc(40);
    bus_write(1'b0, 8'hFF);
    check("R2", "lone FFh ignored", status, 16'(MAX - 10));
    bus_write(1'b0, 8'h00);
    bus_write(1'b0, 8'h55);
    bus_write(1'b0, 8'hFF);
    check("R2", "broken pair ignored", status, 16'(MAX - 11));
    bus_write(1'b0, 8'h00);
    bus_write(1'b0, 8'h00);
    bus_write(1'b0, 8'hFF);
    check("R2", "valid pair reloads", status, 16'(MAX));
    check("R5", "full window accepts", {14'd0, rst_req, nmi_req}, 16'd0);
    wait_cyc(3);
    check("R1", "phase restarted, no decrement yet", status, 16'(MAX));
    wait_cyc(1);
    check("R1", "first decrement one ratio later", status, 16'(MAX - 1));
  endtask

  task automatic t_window;
    do_reset(1'b1, 1'b1, 3'd0, 2'd2, 2'd0);
    wait_cyc(9);
    bus_write(1'b0, 8'h00);
    bus_write(1'b0, 8'hFF);
    check("R5", "early refresh is error", {14'd0, rst_req, nmi_req}, 16'b01);
    check("R5", "error flag and reload", status, 16'h8000 | 16'(MAX));
    wait_cyc(1);
    check("R9", "nmi request one cycle", {15'd0, nmi_req}, 16'd0);
    wait_cyc(140);
    bus_write(1'b0, 8'h00);
    bus_write(1'b0, 8'hFF);
    check("R5", "refresh inside window", {14'd0, rst_req, nmi_req}, 16'd0);
    check("R5", "flag sticky, count reloaded", status, 16'h8000 | 16'(MAX));
    do_reset(1'b1, 1'b1, 3'd0, 2'd0, 2'd3);
    wait_cyc(78);
    bus_write(1'b0, 8'h00);
    bus_write(1'b0, 8'hFF);
    check("R5", "late refresh below end bound", {14'd0, rst_req, nmi_req}, 16'b01);
    bus_write(1'b0, 8'h00);
    bus_write(1'b0, 8'hFF);
    check("R5", "refresh at top of window", {14'd0, rst_req, nmi_req}, 16'd0);
  endtask

  task automatic t_register_start;
    int early = 0;
    do_reset(1'b0, 1'b0, 3'd0, 2'd2, 2'd0);
    wait_cyc(100);
    check("R4", "held before first refresh", status, 16'(MAX));
    bus_write(1'b0, 8'h00);
    bus_write(1'b0, 8'hFF);
    check("R4", "first refresh not window checked", {14'd0, rst_req, nmi_req}, 16'd0);
    for (int i = 1; i <= 4 * (MAX + 1); i++) begin
      @(negedge clk);
      if (i < 4 * (MAX + 1) && rst_req) early++;
    end
    check("R4", "no early request", 16'(early), 16'd0);
    check("R3", "underflow after start", {15'd0, rst_req}, 16'd1);
    wait_cyc(50);
    check("R4", "stopped after fault", status, 16'h4000 | 16'(MAX));
  endtask

  task automatic t_nmi_continue;
    do_reset(1'b1, 1'b1, 3'd0, 2'd0, 2'd0);
    wait_cyc(4 * (MAX + 1));
    check("R6", "nmi request on underflow", {14'd0, rst_req, nmi_req}, 16'b01);
    wait_cyc(8);
    check("R6", "auto mode keeps counting", status, 16'h4000 | 16'(MAX - 2));
  endtask

  task automatic t_stop;
    do_reset(1'b1, 1'b0, 3'd0, 2'd0, 2'd0);
    wait_cyc(10);
    stop = 1'b1;
    wait_cyc(100);
    check("R7", "count frozen", status, 16'(MAX - 2));
    stop = 1'b0;
    wait_cyc(1);
    check("R7", "phase held, no decrement", status, 16'(MAX - 2));
    wait_cyc(1);
    check("R7", "phase resumes", status, 16'(MAX - 3));
  endtask

  task automatic t_ratios;
    for (int s = 1; s <= 7; s++) begin
      if (s == 6) continue;
      do_reset(1'b1, 1'b0, 3'(s), 2'd0, 2'd0);
      wait_cyc(ratio_of(s) - 1);
      check("R1", $sformatf("ratio code %0d before tick", s), status, 16'(MAX));
      wait_cyc(1);
      check("R1", $sformatf("ratio code %0d at tick", s), status, 16'(MAX - 1));
    end
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; stop = 1'b0; auto_st = 1'b1; nmi_sel = 1'b0;
    div_sel = 3'd0; ws = 2'd0; we = 2'd0; wr = 1'b0; addr = 1'b0; wdata = 8'h00;
    @(negedge clk);
    t_reset_state();
    t_underflow_reset();
    t_refresh_seq();
    t_window();
    t_register_start();
    t_nmi_continue();
    t_stop();
    t_ratios();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (R1..R9 run): actual hung expected completion");
    finish_run();
  end
endmodule